// File: doc/BRIEF.md
# Multi-Mode ADC Scan Sequencer

This block sequences an external successive-approximation converter core across eight analog input channels. A register interface sets a channel window (first and last channel), one of four sequencing modes, the result precision and the trigger source. The sequencer asks the core for a conversion with a one-cycle request pulse and a channel number. It then waits for the core's one-cycle completion pulse, which carries a 10-bit sample. The sample is stored in a per-channel result memory that software can read back.

The four modes are single conversion, one pass over the window, endless passes over the window until software stops it, and a stepping mode. In stepping mode each trigger converts exactly one channel, and the sequencer then rests until the next trigger. A sequence can be launched by a software command or by the rising edge of an external trigger pin, which is synchronised first. A sticky interrupt flag marks the end of a single conversion or of a complete pass.

Top module: `adc_seq_top`

## Requirements
- R1: Register map. Address 0 is configuration: bits [2:0] first channel, bits [5:3] last channel, bits [7:6] mode (0 single, 1 one pass, 2 endless, 3 stepping), bit 8 narrow result, bit 9 external trigger select. Address 1 is command/status. A write to it acts as follows: bit 0 is a software launch, bit 1 written as 1 clears the interrupt, bit 2 is stop. A read of it returns bit 0 busy and bit 1 interrupt. Addresses 8 to 15 read the result of channel (address − 8). Read data appears one cycle after the address. After reset every register and output reads zero.
- R2: With narrow result clear, a channel's stored result equals the 10-bit core sample. With it set, the stored result is sample bits [9:2], zero-extended.
- R3: Single mode converts the first channel exactly once and then returns to idle.
- R4: One-pass mode converts channels in ascending order from the first to the last channel, wrapping from 7 to 0 when last < first, and then returns to idle.
- R5: Endless mode repeats the window until a stop command. The conversion in flight at the stop still completes and is stored, and no further request follows.
- R6: Stepping mode converts one channel per trigger and then rests with busy low. The next trigger takes the next channel of the window, returning to the first channel after the last. A stop command returns it to idle.
- R7: Only the selected trigger source launches. The external pin passes through a two-stage synchroniser and acts on its rising edge.
- R8: The interrupt flag sets when a single conversion completes or when the last channel of a window pass completes. The irq output follows the flag.
- R9: Writing 1 to command bit 1 clears the interrupt flag. Writing 0 there leaves it set.
- R10: Busy is high from a launch until the sequence ends or the stepping mode rests. Triggers that arrive while busy are ignored.
- R11: The conversion request is a one-cycle pulse. The channel output changes only together with a request and holds until the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address, read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after address |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_start | output | 1 | Conversion request pulse to the core |
| conv_ch | output | 3 | Channel to convert |
| conv_done | input | 1 | Core completion pulse |
| conv_data | input | 10 | Core sample, valid with conv_done |
| busy | output | 1 | Sequence in progress |
| irq | output | 1 | Completion interrupt flag |

## Verification
Several properties are checked on every cycle. The request is always a single-cycle pulse, and the channel moves only with a request. No request appears while a conversion is outstanding. Busy is high whenever a request is issued, and the interrupt sets only after a completion and then stays set. The synchroniser's edge output never lasts two cycles. Channel order across modes, window wrap, stop timing in endless mode, the stepping rest, the choice of trigger source and the stored 8-bit and 10-bit values are shown only by the bench scenarios. In those scenarios a scoreboard matches every request against the expected channel, and results are read back through the registers.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_CH = 8;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CFG_W  = 2 * CH_W + 4;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_SCAN = 2'd1,
    MODE_LOOP = 2'd2,
    MODE_STEP = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic            trig_ext;
    logic            narrow;
    seq_mode_e       mode;
    logic [CH_W-1:0] last_ch;
    logic [CH_W-1:0] first_ch;
  } seq_cfg_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      prev  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], pin};
      prev  <= shreg[STAGES-1];
    end
  end

  assign rise = shreg[STAGES-1] & ~prev;

  a_r7_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/adc_result_ram.sv
module adc_result_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              irq_set,
  input  logic [RES_W-1:0]  ram_q,
  output logic [CH_W-1:0]   ram_raddr,
  output seq_cfg_t          cfg,
  output logic              sw_start,
  output logic              stop_req,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] ADDR_CFG = '0;
  localparam logic [ADDR_W-1:0] ADDR_CMD = ADDR_W'(1);
  localparam int BIT_GO    = 0;
  localparam int BIT_CLR   = 1;
  localparam int BIT_STOP  = 2;

  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] reg_q;
  logic              sel_res;
  logic              cmd_wr;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:CFG_W];
  assign cmd_wr   = we && (addr == ADDR_CMD);
  assign sw_start = cmd_wr && wdata[BIT_GO];
  assign stop_req = cmd_wr && wdata[BIT_STOP];
  assign ram_raddr = addr[CH_W-1:0];

  assign cfg.first_ch = cfg_q[CH_W-1:0];
  assign cfg.last_ch  = cfg_q[2*CH_W-1:CH_W];
  assign cfg.mode     = seq_mode_e'(cfg_q[2*CH_W+1:2*CH_W]);
  assign cfg.narrow   = cfg_q[2*CH_W+2];
  assign cfg.trig_ext = cfg_q[2*CH_W+3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      irq     <= 1'b0;
      reg_q   <= '0;
      sel_res <= 1'b0;
    end else begin
      if (we && (addr == ADDR_CFG)) cfg_q <= wdata[CFG_W-1:0];
      if (irq_set) irq <= 1'b1;
      else if (cmd_wr && wdata[BIT_CLR]) irq <= 1'b0;
      sel_res <= addr[ADDR_W-1];
      if (addr == ADDR_CFG)      reg_q <= DATA_W'(cfg_q);
      else if (addr == ADDR_CMD) reg_q <= DATA_W'({irq, busy});
      else                       reg_q <= '0;
    end
  end

  assign rdata = sel_res ? DATA_W'(ram_q) : reg_q;

  a_r9_irq_sets: assert property (@(posedge clk) disable iff (rst)
    irq_set |=> irq);
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !cmd_wr) |=> irq);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_cfg_t         cfg,
  input  logic             trig,
  input  logic             stop_req,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  output logic             busy,
  output logic             irq_set,
  output logic             res_we,
  output logic [CH_W-1:0]  res_addr,
  output logic [RES_W-1:0] res_data
);
  seq_state_e      state;
  seq_cfg_t        run_cfg;
  logic            stop_pend;
  logic            at_last;
  logic            stop_any;
  logic [CH_W-1:0] next_ch;
  logic [RES_W-1:0] shaped;

  assign at_last  = (conv_ch == run_cfg.last_ch);
  assign stop_any = stop_pend | stop_req;
  assign next_ch  = at_last ? run_cfg.first_ch :
                    (conv_ch == CH_W'(NUM_CH-1)) ? '0 : conv_ch + 1'b1;
  assign shaped   = run_cfg.narrow ?
                    RES_W'(conv_data[RES_W-1 -: LOW_W]) : conv_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      run_cfg    <= '0;
      stop_pend  <= 1'b0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      busy       <= 1'b0;
      irq_set    <= 1'b0;
      res_we     <= 1'b0;
      res_addr   <= '0;
      res_data   <= '0;
    end else begin
      conv_start <= 1'b0;
      irq_set    <= 1'b0;
      res_we     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (trig) begin
            run_cfg    <= cfg;
            conv_ch    <= cfg.first_ch;
            conv_start <= 1'b1;
            busy       <= 1'b1;
            stop_pend  <= 1'b0;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (stop_req) stop_pend <= 1'b1;
          if (conv_done) begin
            res_we   <= 1'b1;
            res_addr <= conv_ch;
            res_data <= shaped;
            case (run_cfg.mode)
              MODE_ONCE: begin
                irq_set <= 1'b1;
                busy    <= 1'b0;
                state   <= ST_IDLE;
              end
              MODE_SCAN: begin
                if (at_last) irq_set <= 1'b1;
                if (at_last || stop_any) begin
                  busy  <= 1'b0;
                  state <= ST_IDLE;
                end else begin
                  conv_ch    <= next_ch;
                  conv_start <= 1'b1;
                end
              end
              MODE_LOOP: begin
                if (at_last) irq_set <= 1'b1;
                if (stop_any) begin
                  busy  <= 1'b0;
                  state <= ST_IDLE;
                end else begin
                  conv_ch    <= next_ch;
                  conv_start <= 1'b1;
                end
              end
              default: begin
                if (at_last) irq_set <= 1'b1;
                busy  <= 1'b0;
                state <= stop_any ? ST_IDLE : ST_HOLD;
              end
            endcase
          end
        end
        ST_HOLD: begin
          if (stop_req) begin
            state <= ST_IDLE;
          end else if (trig) begin
            conv_ch    <= next_ch;
            conv_start <= 1'b1;
            busy       <= 1'b1;
            stop_pend  <= 1'b0;
            state      <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r11_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  a_r11_ch_moves_with_start: assert property (@(posedge clk) disable iff (rst)
    (conv_ch != $past(conv_ch)) |-> conv_start);
  a_r10_busy_with_start: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);
  a_r10_no_start_outstanding: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !conv_done && !conv_start) |=> !conv_start);
  a_r8_irq_after_done: assert property (@(posedge clk) disable iff (rst)
    irq_set |-> $past(conv_done));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RES_W     = 10,
  parameter int LOW_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              busy,
  output logic              irq
);
  seq_cfg_t        cfg;
  logic            sw_start;
  logic            stop_req;
  logic            ext_rise;
  logic            trig;
  logic            irq_set;
  logic            res_we;
  logic [CH_W-1:0] res_addr;
  logic [RES_W-1:0] res_data;
  logic [CH_W-1:0] ram_raddr;
  logic [RES_W-1:0] ram_q;

  assign trig = cfg.trig_ext ? ext_rise : sw_start;

  adc_trig_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_trig), .rise(ext_rise));

  adc_seq_regs #(.DATA_W(DATA_W), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .irq_set(irq_set), .ram_q(ram_q), .ram_raddr(ram_raddr),
    .cfg(cfg), .sw_start(sw_start), .stop_req(stop_req), .irq(irq),
    .rdata(reg_rdata));

  adc_seq_ctrl #(.RES_W(RES_W), .LOW_W(LOW_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg(cfg), .trig(trig), .stop_req(stop_req),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .conv_ch(conv_ch), .busy(busy), .irq_set(irq_set), .res_we(res_we),
    .res_addr(res_addr), .res_data(res_data));

  adc_result_ram #(.DEPTH(NUM_CH), .WIDTH(RES_W)) u_ram (
    .clk(clk), .we(res_we), .waddr(res_addr), .wdata(res_data),
    .raddr(ram_raddr), .q(ram_q));
endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_trig = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        busy;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int launches = 0;
  int exp_q[$];
  int core_val[8];
  int pend_cnt = 0;
  int pend_ch = 0;
  int sample_no = 0;
  string cur_req = "R3";

  always #5 clk = ~clk;

  adc_seq_top u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .busy(busy), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural converter core plus scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (conv_done) conv_done = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          check(conv_ch == 3'(pend_ch), "R11 channel held", int'(conv_ch), pend_ch);
          core_val[pend_ch] = (pend_ch * 37 + sample_no * 53 + 11) % 1024;
          sample_no++;
          conv_data = 10'(core_val[pend_ch]);
          conv_done = 1'b1;
        end
      end
      if (conv_start && !rst) begin
        launches++;
        if (exp_q.size() == 0) begin
          check(1'b0, {cur_req, " unexpected request"}, int'(conv_ch), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(conv_ch) == e, {cur_req, " channel order"}, int'(conv_ch), e);
        end
        pend_ch  = int'(conv_ch);
        pend_cnt = LAT;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && pend_cnt == 0 && !conv_done && !busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    repeat (3) @(negedge clk); ext_trig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(conv_start == 1'b0 && busy == 1'b0 && irq == 1'b0, "R1 outputs", int'({conv_start, busy, irq}), 0);
    rd(4'd0, v); check(v == 0, "R1 config reads zero", v, 0);
    rd(4'd1, v); check(v == 0, "R1 status reads zero", v, 0);

    // R3 single mode, channel 5, full precision (R2)
    cur_req = "R3";
    wr(4'd0, 16'd5);
    base = launches;
    exp_q.push_back(5);
    wr(4'd1, 16'h0001);
    wait_quiet();
    check(launches - base == 1, "R3 one request", launches - base, 1);
    rd(4'd13, v); check(v == core_val[5], "R2 10-bit result ch5", v, core_val[5]);
    check(irq == 1'b1, "R8 irq after single", int'(irq), 1);
    rd(4'd1, v); check(v == 2, "R10 status idle irq set", v, 2);

    // R9 clear semantics
    wr(4'd1, 16'h0000);
    @(negedge clk); check(irq == 1'b1, "R9 write 0 keeps irq", int'(irq), 1);
    wr(4'd1, 16'h0002);
    @(negedge clk); check(irq == 1'b0, "R9 write 1 clears irq", int'(irq), 0);

    // R4 one pass 2..6, narrow results (R2); R10 busy and ignored retrigger
    cur_req = "R4";
    wr(4'd0, 16'd370);
    for (int c = 2; c <= 6; c++) exp_q.push_back(c);
    base = launches;
    wr(4'd1, 16'h0001);
    while (launches == base) @(negedge clk);
    check(busy == 1'b1, "R10 busy during pass", int'(busy), 1);
    wr(4'd1, 16'h0001);
    wait_quiet();
    check(launches - base == 5, "R4 five requests", launches - base, 5);
    for (int c = 2; c <= 6; c++) begin
      rd(4'(8 + c), v);
      check(v == (core_val[c] >> 2), "R2 8-bit result", v, core_val[c] >> 2);
    end
    check(irq == 1'b1, "R8 irq after pass", int'(irq), 1);
    wr(4'd1, 16'h0002);

    // R4 wrap 6..1
    wr(4'd0, 16'd78);
    exp_q.push_back(6); exp_q.push_back(7); exp_q.push_back(0); exp_q.push_back(1);
    base = launches;
    wr(4'd1, 16'h0001);
    wait_quiet();
    check(launches - base == 4, "R4 wrap count", launches - base, 4);
    rd(4'd8, v); check(v == core_val[0], "R4 wrap result ch0", v, core_val[0]);
    wr(4'd1, 16'h0002);

    // R5 endless 1..2 with stop
    cur_req = "R5";
    wr(4'd0, 16'd145);
    for (int k = 0; k < 3; k++) begin exp_q.push_back(1); exp_q.push_back(2); end
    base = launches;
    wr(4'd1, 16'h0001);
    while (launches < base + 6) @(negedge clk);
    wr(4'd1, 16'h0004);
    wait_quiet();
    repeat (30) @(negedge clk);
    check(launches - base == 6, "R5 no request after stop", launches - base, 6);
    rd(4'd10, v); check(v == core_val[2], "R5 in-flight result stored", v, core_val[2]);
    check(irq == 1'b1, "R8 irq after endless pass", int'(irq), 1);
    wr(4'd1, 16'h0002);

    // R6 stepping 3..4 on external trigger (R7)
    cur_req = "R6";
    wr(4'd0, 16'd739);
    base = launches;
    exp_q.push_back(3);
    pulse_ext();
    wait_quiet();
    repeat (20) @(negedge clk);
    check(launches - base == 1, "R6 rests after one", launches - base, 1);
    check(busy == 1'b0 && irq == 1'b0, "R6 rest busy low no irq", int'({busy, irq}), 0);
    cur_req = "R7";
    wr(4'd1, 16'h0001);
    repeat (20) @(negedge clk);
    check(launches - base == 1, "R7 software launch ignored", launches - base, 1);
    cur_req = "R6";
    exp_q.push_back(4);
    pulse_ext();
    wait_quiet();
    check(irq == 1'b1, "R8 irq at window end", int'(irq), 1);
    exp_q.push_back(3);
    pulse_ext();
    wait_quiet();
    check(launches - base == 3, "R6 wrap to first", launches - base, 3);
    rd(4'd11, v); check(v == core_val[3], "R6 result ch3", v, core_val[3]);
    wr(4'd1, 16'h0006);

    // R7 external edge ignored when software source selected
    cur_req = "R7";
    wr(4'd0, 16'd5);
    base = launches;
    pulse_ext();
    repeat (20) @(negedge clk);
    check(launches == base, "R7 pin ignored", launches - base, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule